// File: doc/BRIEF.md
# Load/Store Data Alignment Unit

This unit stands between an integer pipeline and a synchronous, write-through data memory port. For every request it adds a register base to a sign-extended 16-bit displacement to get the effective address. It then carries out the access the operation code asks for. On the load side it selects the addressed byte, half-word or word from the fetched memory word and sign- or zero-extends it. For the two unaligned-word load forms, it merges a slice of the memory word into the current register value.

Full-word stores go straight to memory in one cycle. Every narrower store, and both unaligned-word store forms, are done as a read-modify-write: the unit reads the containing word, replaces only the addressed bytes and writes the whole word back. The byte order is taken from a runtime input at the moment a request is accepted. Little-endian order puts address byte 0 in bits 7:0; big-endian order puts it in bits 31:24. While a read or a read-modify-write is in progress the unit reports busy and does not take new requests. A half-word or word access whose address is not naturally aligned is refused with an address-error pulse.

Top module: `lsu_align`

## Requirements
- R1: The effective address is `req_base` plus `req_offset` sign-extended to 32 bits. `mem_addr` always carries the effective address with bits 1:0 cleared. Operation codes: 0 signed byte load, 1 unsigned byte load, 2 signed half load, 3 unsigned half load, 4 word load, 5 left-unaligned load, 6 right-unaligned load, 8 byte store, 9 half store, 10 word store, 11 left-unaligned store, 12 right-unaligned store.
- R2: A byte load returns the byte at address offset a. That byte sits in lane a (bits 8a+7:8a) in little-endian mode and in lane 3-a in big-endian mode. Code 0 sign-extends it and code 1 zero-extends it.
- R3: A half-word load at an even offset a returns bytes a and a+1, extended by sign (code 2) or with zeros (code 3). Byte a is the upper byte in big-endian mode and the lower byte in little-endian mode.
- R4: Every load issues a memory read in the cycle after acceptance. `resp_valid` pulses with the result one cycle after the memory returns the word, so the result is registered at the second clock edge after the read is issued. A word load (code 4) returns the word unchanged.
- R5: The left-unaligned load places memory bytes a and onward, in address order, into the register starting from its most significant byte; its other register bytes keep the value of `req_rtval`. The right-unaligned load places bytes up to a, with the last of them in the least significant byte; its other register bytes also keep the value of `req_rtval`. Both take the direction of "onward" from the endian mode and never raise an address error.
- R6: A word store at an aligned address writes `req_wdata` in a single memory write in the cycle after acceptance, without raising busy.
- R7: Byte and half-word stores read the containing word first. Two clock edges later they write it back with only the addressed bytes replaced, using the lane rules of R2 and R3, and the low byte or half of `req_wdata`.
- R8: The left-unaligned store writes register bytes from the most significant end into memory bytes a and onward. The right-unaligned store writes register bytes from the least significant end into memory bytes up to a. All other memory bytes keep their old value, and both are done as a read-modify-write.
- R9: A half-word access at an odd address, or a word load or store whose address has bits 1:0 not zero, pulses `addr_err` for one cycle. It performs no memory access and produces no response.
- R10: `busy` is high for exactly the two cycles between a read and its completion. A request presented while busy is ignored and leaves memory and outputs untouched.
- R11: After reset `busy`, `mem_en`, `mem_we`, `resp_valid` and `addr_err` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 4 | Operation code (see R1) |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store source register value |
| req_rtval | input | 32 | Current destination register value for unaligned loads |
| big_endian | input | 1 | 1 selects big-endian byte order |
| busy | output | 1 | Read or read-modify-write in progress; requests ignored |
| resp_valid | output | 1 | Load result valid pulse |
| resp_data | output | 32 | Load result |
| addr_err | output | 1 | Misaligned access pulse |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write word |
| mem_rdata | input | 32 | Read word, valid the cycle after the read strobe |

## Verification
The bench is built around timing counted from the clock edge that accepts a request. `addr_err` and the single write of a word store appear one edge after acceptance. A load's or a partial store's read strobe also appears one edge after acceptance. The load response, or the merged write, follows two edges after that read. The behavioural model counts the same edges and compares every output in the middle of each clock period. A fault that shifts a result by one cycle therefore shows up as a mismatch, not as a late match.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OP_LB  = 4'd0;
  localparam logic [OP_W-1:0] OP_LBU = 4'd1;
  localparam logic [OP_W-1:0] OP_LH  = 4'd2;
  localparam logic [OP_W-1:0] OP_LHU = 4'd3;
  localparam logic [OP_W-1:0] OP_LW  = 4'd4;
  localparam logic [OP_W-1:0] OP_LWL = 4'd5;
  localparam logic [OP_W-1:0] OP_LWR = 4'd6;
  localparam logic [OP_W-1:0] OP_SB  = 4'd8;
  localparam logic [OP_W-1:0] OP_SH  = 4'd9;
  localparam logic [OP_W-1:0] OP_SW  = 4'd10;
  localparam logic [OP_W-1:0] OP_SWL = 4'd11;
  localparam logic [OP_W-1:0] OP_SWR = 4'd12;

  typedef enum logic [1:0] {SZ_BYTE, SZ_HALF, SZ_WORD, SZ_UNAL} lsu_size_e;

  typedef enum logic [1:0] {ST_IDLE, ST_RD1, ST_RD2} lsu_state_e;

  typedef struct packed {
    logic      valid;
    logic      is_load;
    logic      sext;
    lsu_size_e size;
    logic      left;
  } lsu_dec_t;

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int LSB_W  = 2
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [OP_W-1:0]   op_i,
  output logic [ADDR_W-1:0] ea_o,
  output lsu_dec_t          dec_o,
  output logic              misal_o
);

  localparam int EXT_W = ADDR_W - OFF_W;

  assign ea_o = base_i + {{EXT_W{off_i[OFF_W-1]}}, off_i};

  always_comb begin
    dec_o = '0;
    unique case (op_i)
      OP_LB:   dec_o = '{valid: 1'b1, is_load: 1'b1, sext: 1'b1, size: SZ_BYTE, left: 1'b0};
      OP_LBU:  dec_o = '{valid: 1'b1, is_load: 1'b1, sext: 1'b0, size: SZ_BYTE, left: 1'b0};
      OP_LH:   dec_o = '{valid: 1'b1, is_load: 1'b1, sext: 1'b1, size: SZ_HALF, left: 1'b0};
      OP_LHU:  dec_o = '{valid: 1'b1, is_load: 1'b1, sext: 1'b0, size: SZ_HALF, left: 1'b0};
      OP_LW:   dec_o = '{valid: 1'b1, is_load: 1'b1, sext: 1'b0, size: SZ_WORD, left: 1'b0};
      OP_LWL:  dec_o = '{valid: 1'b1, is_load: 1'b1, sext: 1'b0, size: SZ_UNAL, left: 1'b1};
      OP_LWR:  dec_o = '{valid: 1'b1, is_load: 1'b1, sext: 1'b0, size: SZ_UNAL, left: 1'b0};
      OP_SB:   dec_o = '{valid: 1'b1, is_load: 1'b0, sext: 1'b0, size: SZ_BYTE, left: 1'b0};
      OP_SH:   dec_o = '{valid: 1'b1, is_load: 1'b0, sext: 1'b0, size: SZ_HALF, left: 1'b0};
      OP_SW:   dec_o = '{valid: 1'b1, is_load: 1'b0, sext: 1'b0, size: SZ_WORD, left: 1'b0};
      OP_SWL:  dec_o = '{valid: 1'b1, is_load: 1'b0, sext: 1'b0, size: SZ_UNAL, left: 1'b1};
      OP_SWR:  dec_o = '{valid: 1'b1, is_load: 1'b0, sext: 1'b0, size: SZ_UNAL, left: 1'b0};
      default: dec_o = '0;
    endcase
  end

  // Natural alignment is only demanded of half and full word accesses (R9).
  always_comb begin
    unique case (dec_o.size)
      SZ_HALF: misal_o = ea_o[0];
      SZ_WORD: misal_o = |ea_o[LSB_W-1:0];
      default: misal_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/lsu_load_fmt.sv
module lsu_load_fmt
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LSB_W  = 2
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic [DATA_W-1:0] rt_i,
  input  lsu_size_e         size_i,
  input  logic              sext_i,
  input  logic              left_i,
  input  logic [LSB_W-1:0]  ofs_i,
  input  logic              be_i,
  output logic [DATA_W-1:0] res_o
);

  localparam int NB = DATA_W / 8;
  localparam logic [LSB_W-1:0] TOP_LANE  = LSB_W'(NB - 1);
  localparam logic [LSB_W-1:0] HALF_TOP  = LSB_W'(NB - 2);
  localparam logic [DATA_W-1:0] ONES     = '1;

  logic [LSB_W-1:0] lane, hlane, kept_lo, kept_hi;
  logic [7:0]       byte_v;
  logic [15:0]      half_v;

  // Lane that holds the addressed byte / half for the current byte order.
  assign lane    = be_i ? TOP_LANE - ofs_i : ofs_i;
  assign hlane   = be_i ? HALF_TOP - ofs_i : ofs_i;
  // Byte counts kept from the register for the left and right forms.
  assign kept_lo = be_i ? ofs_i : TOP_LANE - ofs_i;
  assign kept_hi = TOP_LANE - kept_lo;

  assign byte_v = 8'(word_i >> {lane, 3'b000});
  assign half_v = 16'(word_i >> {hlane, 3'b000});

  always_comb begin
    unique case (size_i)
      SZ_BYTE: res_o = {{(DATA_W-8){sext_i & byte_v[7]}}, byte_v};
      SZ_HALF: res_o = {{(DATA_W-16){sext_i & half_v[15]}}, half_v};
      SZ_WORD: res_o = word_i;
      default: begin
        if (left_i)
          res_o = (word_i << {kept_lo, 3'b000}) | (rt_i & ~(ONES << {kept_lo, 3'b000}));
        else
          res_o = (word_i >> {kept_hi, 3'b000}) | (rt_i & ~(ONES >> {kept_hi, 3'b000}));
      end
    endcase
  end

endmodule

// File: rtl/lsu_store_merge.sv
module lsu_store_merge
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LSB_W  = 2
) (
  input  logic [DATA_W-1:0] old_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  lsu_size_e         size_i,
  input  logic              left_i,
  input  logic [LSB_W-1:0]  ofs_i,
  input  logic              be_i,
  output logic [DATA_W-1:0] merged_o
);

  localparam int NB = DATA_W / 8;
  localparam logic [LSB_W-1:0]  TOP_LANE = LSB_W'(NB - 1);
  localparam logic [LSB_W-1:0]  HALF_TOP = LSB_W'(NB - 2);
  localparam logic [DATA_W-1:0] ONES     = '1;
  localparam logic [DATA_W-1:0] BYTE_M   = DATA_W'(8'hFF);
  localparam logic [DATA_W-1:0] HALF_M   = DATA_W'(16'hFFFF);

  logic [LSB_W-1:0]  lane, hlane, skip_hi, skip_lo;
  logic [DATA_W-1:0] new_v, mask_v;

  assign lane    = be_i ? TOP_LANE - ofs_i : ofs_i;
  assign hlane   = be_i ? HALF_TOP - ofs_i : ofs_i;
  assign skip_hi = be_i ? ofs_i : TOP_LANE - ofs_i;
  assign skip_lo = TOP_LANE - skip_hi;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: begin
        new_v  = {{(DATA_W-8){1'b0}}, wdata_i[7:0]} << {lane, 3'b000};
        mask_v = BYTE_M << {lane, 3'b000};
      end
      SZ_HALF: begin
        new_v  = {{(DATA_W-16){1'b0}}, wdata_i[15:0]} << {hlane, 3'b000};
        mask_v = HALF_M << {hlane, 3'b000};
      end
      SZ_WORD: begin
        new_v  = wdata_i;
        mask_v = ONES;
      end
      default: begin
        if (left_i) begin
          new_v  = wdata_i >> {skip_hi, 3'b000};
          mask_v = ONES >> {skip_hi, 3'b000};
        end else begin
          new_v  = wdata_i << {skip_lo, 3'b000};
          mask_v = ONES << {skip_lo, 3'b000};
        end
      end
    endcase
  end

  assign merged_o = (old_i & ~mask_v) | (new_v & mask_v);

endmodule

// File: rtl/lsu_align.sv
module lsu_align
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [OP_W-1:0]   req_op,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] req_rtval,
  input  logic              big_endian,
  output logic              busy,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_data,
  output logic              addr_err,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int LSB_W = $clog2(DATA_W / 8);

  lsu_state_e        st;
  logic [ADDR_W-1:0] ea;
  lsu_dec_t          dec;
  logic              misal;

  logic              ctx_load, ctx_sext, ctx_left, ctx_be;
  lsu_size_e         ctx_size;
  logic [LSB_W-1:0]  ctx_ofs;
  logic [DATA_W-1:0] ctx_wdata, ctx_rt;
  logic [DATA_W-1:0] ld_res, st_res;

  lsu_agen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LSB_W(LSB_W)) agen_i (
    .base_i  (req_base),
    .off_i   (req_offset),
    .op_i    (req_op),
    .ea_o    (ea),
    .dec_o   (dec),
    .misal_o (misal)
  );

  lsu_load_fmt #(.DATA_W(DATA_W), .LSB_W(LSB_W)) ldfmt_i (
    .word_i (mem_rdata),
    .rt_i   (ctx_rt),
    .size_i (ctx_size),
    .sext_i (ctx_sext),
    .left_i (ctx_left),
    .ofs_i  (ctx_ofs),
    .be_i   (ctx_be),
    .res_o  (ld_res)
  );

  lsu_store_merge #(.DATA_W(DATA_W), .LSB_W(LSB_W)) merge_i (
    .old_i    (mem_rdata),
    .wdata_i  (ctx_wdata),
    .size_i   (ctx_size),
    .left_i   (ctx_left),
    .ofs_i    (ctx_ofs),
    .be_i     (ctx_be),
    .merged_o (st_res)
  );

  assign busy = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      mem_en     <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      resp_valid <= 1'b0;
      resp_data  <= '0;
      addr_err   <= 1'b0;
      ctx_load   <= 1'b0;
      ctx_sext   <= 1'b0;
      ctx_left   <= 1'b0;
      ctx_be     <= 1'b0;
      ctx_size   <= SZ_BYTE;
      ctx_ofs    <= '0;
      ctx_wdata  <= '0;
      ctx_rt     <= '0;
    end else begin
      mem_en     <= 1'b0;
      mem_we     <= 1'b0;
      resp_valid <= 1'b0;
      addr_err   <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (req_valid && dec.valid) begin
            if (misal) begin
              addr_err <= 1'b1;
            end else begin
              mem_en   <= 1'b1;
              mem_addr <= {ea[ADDR_W-1:LSB_W], {LSB_W{1'b0}}};
              if (!dec.is_load && dec.size == SZ_WORD) begin
                mem_we    <= 1'b1;
                mem_wdata <= req_wdata;
              end else begin
                st        <= ST_RD1;
                ctx_load  <= dec.is_load;
                ctx_sext  <= dec.sext;
                ctx_left  <= dec.left;
                ctx_size  <= dec.size;
                ctx_ofs   <= ea[LSB_W-1:0];
                ctx_be    <= big_endian;
                ctx_wdata <= req_wdata;
                ctx_rt    <= req_rtval;
              end
            end
          end
        end
        ST_RD1: st <= ST_RD2;
        ST_RD2: begin
          st <= ST_IDLE;
          if (ctx_load) begin
            resp_valid <= 1'b1;
            resp_data  <= ld_res;
          end else begin
            mem_en    <= 1'b1;
            mem_we    <= 1'b1;
            mem_wdata <= st_res;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lsu_align_chk.sv
module lsu_align_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       resp_valid,
  input logic       addr_err,
  input logic       mem_en,
  input logic       mem_we,
  input logic [1:0] addr_lo
);

  p_addr_aligned_r1: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> addr_lo == 2'b00);

  p_load_latency_r4: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> $past(mem_en && !mem_we, 2));

  p_resp_idle_r4: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> !busy);

  p_rmw_order_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_we && $past(busy)) |-> $past(mem_en && !mem_we, 2));

  p_err_no_access_r9: assert property (@(posedge clk) disable iff (rst)
    addr_err |-> !mem_en);

  p_err_no_resp_r9: assert property (@(posedge clk) disable iff (rst)
    !(resp_valid && addr_err));

  p_no_write_busy_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && mem_en) |-> !mem_we);

  p_busy_span_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |=> !busy);

endmodule

bind lsu_align lsu_align_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .resp_valid (resp_valid),
  .addr_err   (addr_err),
  .mem_en     (mem_en),
  .mem_we     (mem_we),
  .addr_lo    (mem_addr[1:0])
);

// File: tb/lsu_align_tb_top.sv
module lsu_align_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [3:0]  req_op = '0;
  logic [31:0] req_base = '0;
  logic [15:0] req_offset = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] req_rtval = '0;
  logic        big_endian = 1'b0;
  logic        busy, resp_valid, addr_err, mem_en, mem_we;
  logic [31:0] resp_data, mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsu_align dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_base(req_base), .req_offset(req_offset), .req_wdata(req_wdata),
    .req_rtval(req_rtval), .big_endian(big_endian), .busy(busy),
    .resp_valid(resp_valid), .resp_data(resp_data), .addr_err(addr_err),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Synchronous memory environment: 16 words, one-cycle read latency.
  logic [31:0] ram [16];
  logic [31:0] ref_mem [16];

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) ram[mem_addr[5:2]] <= mem_wdata;
      else        mem_rdata <= ram[mem_addr[5:2]];
    end
  end

  // Behavioural reference, written in address order of bytes.
  function automatic logic [31:0] pack(input logic [7:0] b [4], input bit be);
    logic [31:0] w;
    for (int i = 0; i < 4; i++) w[(be ? 8*(3-i) : 8*i) +: 8] = b[i];
    return w;
  endfunction

  function automatic logic [31:0] ld_model(input logic [3:0] op, input logic [31:0] w,
                                           input logic [31:0] rt, input int a, input bit be);
    logic [7:0]  mb [4];
    logic [7:0]  rb [4];
    logic [15:0] h;
    logic [31:0] r;
    for (int i = 0; i < 4; i++) begin
      mb[i] = be ? w[8*(3-i) +: 8] : w[8*i +: 8];
      rb[i] = rt[8*i +: 8];
    end
    r = '0;
    case (op)
      4'd0: r = {{24{mb[a][7]}}, mb[a]};
      4'd1: r = {24'h0, mb[a]};
      4'd2, 4'd3: begin
        h = be ? {mb[a], mb[a+1]} : {mb[a+1], mb[a]};
        r = (op == 4'd2) ? {{16{h[15]}}, h} : {16'h0, h};
      end
      4'd4: r = w;
      4'd5: begin
        for (int i = 0; i < 4; i++) begin
          if (be && i >= a)  rb[3-(i-a)] = mb[i];
          if (!be && i <= a) rb[3-(a-i)] = mb[i];
        end
        r = {rb[3], rb[2], rb[1], rb[0]};
      end
      default: begin
        for (int i = 0; i < 4; i++) begin
          if (be && i <= a)  rb[a-i] = mb[i];
          if (!be && i >= a) rb[i-a] = mb[i];
        end
        r = {rb[3], rb[2], rb[1], rb[0]};
      end
    endcase
    return r;
  endfunction

  function automatic logic [31:0] st_model(input logic [3:0] op, input logic [31:0] old,
                                           input logic [31:0] wd, input int a, input bit be);
    logic [7:0] mb [4];
    logic [7:0] rb [4];
    for (int i = 0; i < 4; i++) begin
      mb[i] = be ? old[8*(3-i) +: 8] : old[8*i +: 8];
      rb[i] = wd[8*i +: 8];
    end
    case (op)
      4'd8: mb[a] = rb[0];
      4'd9: begin
        if (be) begin mb[a] = rb[1]; mb[a+1] = rb[0]; end
        else    begin mb[a] = rb[0]; mb[a+1] = rb[1]; end
      end
      4'd11: for (int i = 0; i < 4; i++) begin
        if (be && i >= a)  mb[i] = rb[3-(i-a)];
        if (!be && i <= a) mb[i] = rb[3-(a-i)];
      end
      default: for (int i = 0; i < 4; i++) begin
        if (be && i <= a)  mb[i] = rb[a-i];
        if (!be && i >= a) mb[i] = rb[i-a];
      end
    endcase
    return pack(mb, be);
  endfunction

  // Expected outputs, advanced once per rising edge.
  int          cnt = 0;
  bit          e_en, e_we, e_rv, e_err;
  logic [31:0] e_addr, e_wd, e_rd;
  string       e_tag = "R11";
  bit          p_load, p_be;
  logic [3:0]  p_op;
  logic [31:0] p_wd, p_rt, p_wa;
  int          p_a;
  string       p_tag;

  always @(posedge clk) begin
    logic [31:0] ea;
    int a;
    bit known, load, mis;
    if (rst) begin
      cnt = 0; e_en = 0; e_we = 0; e_rv = 0; e_err = 0; e_tag = "R11";
    end else begin
      e_en = 0; e_we = 0; e_rv = 0; e_err = 0; e_tag = "R10";
      if (cnt == 2) begin
        cnt = 1;
      end else if (cnt == 1) begin
        cnt = 0;
        e_tag = p_tag;
        if (p_load) begin
          e_rv = 1;
          e_rd = ld_model(p_op, ref_mem[p_wa[5:2]], p_rt, p_a, p_be);
        end else begin
          e_en = 1; e_we = 1;
          e_wd = st_model(p_op, ref_mem[p_wa[5:2]], p_wd, p_a, p_be);
          ref_mem[p_wa[5:2]] = e_wd;
        end
      end else if (req_valid) begin
        ea    = req_base + {{16{req_offset[15]}}, req_offset};
        a     = int'(ea[1:0]);
        known = (req_op <= 4'd6) || (req_op >= 4'd8 && req_op <= 4'd12);
        load  = (req_op <= 4'd6);
        mis   = ((req_op == 4'd2 || req_op == 4'd3 || req_op == 4'd9) && ea[0]) ||
                ((req_op == 4'd4 || req_op == 4'd10) && ea[1:0] != 2'b00);
        if (known) begin
          if (mis) begin
            e_err = 1; e_tag = "R9";
          end else begin
            e_en = 1; e_addr = {ea[31:2], 2'b00};
            if (req_op == 4'd10) begin
              e_we = 1; e_wd = req_wdata; e_tag = "R6";
              ref_mem[ea[5:2]] = req_wdata;
            end else begin
              cnt = 2; p_load = load; p_op = req_op; p_wd = req_wdata; p_rt = req_rtval;
              p_wa = e_addr; p_a = a; p_be = big_endian;
              case (req_op)
                4'd0, 4'd1:   p_tag = "R2";
                4'd2, 4'd3:   p_tag = "R3";
                4'd4:         p_tag = "R4";
                4'd5, 4'd6:   p_tag = "R5";
                4'd8, 4'd9:   p_tag = "R7";
                default:      p_tag = "R8";
              endcase
              e_tag = p_tag;
            end
          end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h @%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(busy == (cnt != 0), "R10", "busy", 32'(busy), 32'(cnt != 0));
      chk(mem_en == e_en, e_tag, "mem_en", 32'(mem_en), 32'(e_en));
      chk(addr_err == e_err, "R9", "addr_err", 32'(addr_err), 32'(e_err));
      chk(resp_valid == e_rv, e_tag, "resp_valid", 32'(resp_valid), 32'(e_rv));
      if (e_en) begin
        chk(mem_we == e_we, e_tag, "mem_we", 32'(mem_we), 32'(e_we));
        chk(mem_addr == e_addr, "R1", "mem_addr", mem_addr, e_addr);
        if (e_we) chk(mem_wdata == e_wd, e_tag, "mem_wdata", mem_wdata, e_wd);
      end
      if (e_rv) chk(resp_data == e_rd, e_tag, "resp_data", resp_data, e_rd);
    end
  end

  task automatic issue(input logic [3:0] op, input logic [31:0] base, input logic [15:0] off,
                       input logic [31:0] wd, input logic [31:0] rt);
    while (busy) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_base = base; req_offset = off;
    req_wdata = wd; req_rtval = rt;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=%0d expected=%0d", 50000, 0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      ram[i]     = 32'hA0B1C2D3 + 32'(i) * 32'h1F2E3D4C;
      ref_mem[i] = 32'hA0B1C2D3 + 32'(i) * 32'h1F2E3D4C;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: idle outputs right after reset
    chk(!busy && !mem_en && !mem_we && !resp_valid && !addr_err, "R11", "reset outputs",
        {27'h0, busy, mem_en, mem_we, resp_valid, addr_err}, 32'h0);
    cmp_on = 1'b1;

    // R2 R3 R4 R5 R7 R8 R9 in both byte orders at every offset, with negative displacement (R1)
    for (int be = 0; be < 2; be++) begin
      big_endian = be[0];
      for (int a = 0; a < 4; a++) begin
        for (int op = 0; op < 13; op++) begin
          if (op != 7)
            issue(4'(op), 32'h30, 16'hFFF0 + 16'(a),
                  32'h8C7E5A13 ^ (32'(a + op) * 32'h01030507), 32'h55667788 + 32'(op));
        end
      end
    end

    // R1: positive displacement and wrap to a low address; R6 aligned word store
    big_endian = 1'b1;
    issue(4'd10, 32'h4, 16'h0008, 32'hDEADBEEF, 32'h0);
    issue(4'd4, 32'h4, 16'h0008, 32'h0, 32'h0);
    issue(4'd1, 32'h40, 16'hFFCD, 32'h0, 32'h0);
    // R9: misaligned half and word accesses
    issue(4'd9, 32'h10, 16'h0003, 32'h1234, 32'h0);
    issue(4'd10, 32'h10, 16'h0002, 32'h1234, 32'h0);
    issue(4'd3, 32'h10, 16'h0001, 32'h0, 32'h0);

    // R10: a word store held during a busy load is ignored, then read back
    while (busy) @(negedge clk);
    req_valid = 1'b1; req_op = 4'd4; req_base = 32'h18; req_offset = 16'h0;
    @(negedge clk);
    req_op = 4'd10; req_base = 32'h1C; req_wdata = 32'h0BADF00D;
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    issue(4'd4, 32'h1C, 16'h0, 32'h0, 32'h0);

    // R10: endian switch between two byte loads of the same address
    big_endian = 1'b0;
    issue(4'd0, 32'h1C, 16'h1, 32'h0, 32'h0);
    big_endian = 1'b1;
    issue(4'd0, 32'h1C, 16'h1, 32'h0, 32'h0);

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule